// File: doc/BRIEF.md
# PLL Calibration and Lock Supervisor

This block is the digital supervisor of a crystal-oscillator phase-locked loop. It picks one of three operating modes from two control pins. It runs a successive-approximation search that finds the 6-bit oscillator range code. It turns a noisy raw lock indication into a steady lock output, and it decides when calibration has to run again. The analog oscillator, the phase detector and the loop filter sit outside. They receive the range code and return two signals: a comparator bit saying the oscillator is running too fast, and the raw lock bit.

With the manual-select pin low, the auto-restart pin chooses between two policies. In hold mode, calibration runs only after a reset. In auto mode, calibration runs after a reset and again every time the filtered lock drops. With the manual-select pin high, calibration stops. The restart pin and the auto-restart pin become the top two bits of the range code, and the lock output follows the raw lock bit with no filtering. All control state is held in three copies that are majority-voted and rewritten on every clock. A disagreement between the copies raises a one-cycle error flag. Two test inputs can invert one bit of one copy, so that the voting can be exercised.

Top module: `pll_cal_supervisor`

## Requirements
- R1: The mode comes from ext_ctrl and auto_sel4. When ext_ctrl=1 the mode is manual, whatever auto_sel4 is. When ext_ctrl=0, auto_sel4=0 selects hold mode and auto_sel4=1 selects auto mode.
- R2: When ext_ctrl=0, a low restart_n_sel5 is a synchronous reset. After it, range_code=6'b100000, locked=0, cal_busy=1 and seu_err=0.
- R3: After reset is released, calibration decides one bit per SETTLE_CYC cycles, starting at the MSB. A trial bit is cleared when too_fast=1 (too_fast means the oscillator is faster than wanted for the present range_code). cal_busy falls on clock edge 6*SETTLE_CYC+1 after release. range_code then equals the largest code for which too_fast is 0.
- R4: In hold and auto modes, raw_lock is sampled once every CHECK_PER cycles. locked rises only after LOCK_N consecutive samples are high.
- R5: Once locked, it falls only after UNLOCK_M consecutive samples are low.
- R6: While cal_busy=1, locked is 0.
- R7: In hold mode, a fall of locked does not start calibration. cal_busy stays 0 and range_code keeps its value.
- R8: In auto mode, the clock edge that drops locked also raises cal_busy. A fresh search then runs against the present comparator.
- R9: In manual mode, range_code is {restart_n_sel5, auto_sel4, range_lo} (bit 5, bit 4, bits 3:0), one edge after those pins. restart_n_sel5 does not reset. The calibrated code is frozen and shows again when the block leaves manual mode.
- R10: In manual mode, locked is raw_lock delayed by one edge, and cal_busy is 0.
- R11: A pulse on one upset_copy bit inverts state bit upset_idx (any index below 8) in that copy on the next edge. The outputs keep their values. seu_err is 1 for exactly one cycle, starting on the second edge after the injection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_ctrl | input | 1 | Manual mode select |
| auto_sel4 | input | 1 | Auto-restart enable; range bit 4 in manual mode |
| restart_n_sel5 | input | 1 | Active-low restart; range bit 5 in manual mode |
| range_lo | input | CODE_W-2 | Range bits 3:0 in manual mode |
| too_fast | input | 1 | Comparator: oscillator above target for the present code |
| raw_lock | input | 1 | Unfiltered lock indication from the loop |
| upset_copy | input | 3 | One-hot copy selector for bit-flip injection |
| upset_idx | input | 8 | State bit index to invert |
| range_code | output | CODE_W | Oscillator range code |
| locked | output | 1 | Lock status, filtered or raw depending on mode |
| cal_busy | output | 1 | Calibration in progress |
| seu_err | output | 1 | Copy disagreement flag |

## Verification
The search result and the fall of cal_busy are due on edge 6*SETTLE_CYC+1 after reset release. The bench samples exactly there, and checks the edge before it for the busy state. The filter's sampling phase is hidden from the bench, so raw_lock is held for whole multiples of CHECK_PER edges. A window of N periods then holds exactly N samples. The bench checks the earliest and the latest edge on which locked may change. In manual mode, code and lock are checked one edge after each random pin change. seu_err is checked on the edge after an injection (still low), on the next edge (high) and on the one after that (low again).

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD   = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_MANUAL = 2'd2
  } op_mode_e;

  typedef enum logic {
    PH_CAL   = 1'b0,
    PH_TRACK = 1'b1
  } phase_e;

endpackage

// File: rtl/pll_mode_decode.sv
module pll_mode_decode
  import pll_sup_pkg::*;
(
  input  logic     ext_ctrl,
  input  logic     auto_sel4,
  output op_mode_e mode
);

  // R1: manual select overrides the auto-restart pin
  always_comb begin
    if (ext_ctrl)       mode = MODE_MANUAL;
    else if (auto_sel4) mode = MODE_AUTO;
    else                mode = MODE_HOLD;
  end

endmodule

// File: rtl/pll_cal_engine.sv
module pll_cal_engine
  import pll_sup_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int SETTLE_CYC = 4,
  localparam int BIW = $clog2(CODE_W),
  localparam int SCW = $clog2(SETTLE_CYC)
) (
  input  logic              active,
  input  logic              relaunch,
  input  logic              too_fast,
  input  phase_e            ph_q,
  input  logic [BIW-1:0]    bit_q,
  input  logic [CODE_W-1:0] code_q,
  input  logic [SCW-1:0]    settle_q,
  output phase_e            ph_d,
  output logic [BIW-1:0]    bit_d,
  output logic [CODE_W-1:0] code_d,
  output logic [SCW-1:0]    settle_d
);

  localparam logic [SCW-1:0]    SETTLE_LAST = SCW'(SETTLE_CYC - 1);
  localparam logic [BIW-1:0]    TOP_BIT     = BIW'(CODE_W - 1);
  localparam logic [CODE_W-1:0] FIRST_TRY   = {1'b1, {(CODE_W-1){1'b0}}};

  // R3: successive approximation, MSB first, one decision per settle window
  always_comb begin
    ph_d     = ph_q;
    bit_d    = bit_q;
    code_d   = code_q;
    settle_d = settle_q;
    if (active) begin
      if (ph_q == PH_TRACK) begin
        if (relaunch) begin
          ph_d     = PH_CAL;
          bit_d    = TOP_BIT;
          code_d   = FIRST_TRY;
          settle_d = '0;
        end
      end else if (settle_q != SETTLE_LAST) begin
        settle_d = settle_q + 1'b1;
      end else begin
        settle_d = '0;
        if (too_fast) code_d[bit_q] = 1'b0;
        if (bit_q == '0) begin
          ph_d = PH_TRACK;
        end else begin
          bit_d = bit_q - 1'b1;
          code_d[bit_q - 1'b1] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter #(
  parameter int CHECK_PER = 4,
  parameter int LOCK_N    = 3,
  parameter int UNLOCK_M  = 2,
  localparam int PCW     = $clog2(CHECK_PER),
  localparam int RUN_MAX = (LOCK_N > UNLOCK_M) ? LOCK_N : UNLOCK_M,
  localparam int RCW     = $clog2(RUN_MAX + 1)
) (
  input  logic           active,
  input  logic           tracking,
  input  logic           raw_lock,
  input  logic [PCW-1:0] per_q,
  input  logic [RCW-1:0] run_q,
  input  logic           filt_q,
  output logic [PCW-1:0] per_d,
  output logic [RCW-1:0] run_d,
  output logic           filt_d,
  output logic           lost
);

  localparam logic [PCW-1:0] PER_LAST = PCW'(CHECK_PER - 1);
  localparam logic [RCW-1:0] NEED_N   = RCW'(LOCK_N - 1);
  localparam logic [RCW-1:0] NEED_M   = RCW'(UNLOCK_M - 1);

  // R4/R5: count consecutive samples that disagree with the filtered state
  always_comb begin
    per_d  = per_q;
    run_d  = run_q;
    filt_d = filt_q;
    lost   = 1'b0;
    if (active) begin
      if (!tracking) begin
        per_d  = '0;
        run_d  = '0;
        filt_d = 1'b0;
      end else if (per_q != PER_LAST) begin
        per_d = per_q + 1'b1;
      end else begin
        per_d = '0;
        if (raw_lock == filt_q) begin
          run_d = '0;
        end else if (run_q == (filt_q ? NEED_M : NEED_N)) begin
          run_d  = '0;
          filt_d = raw_lock;
          lost   = filt_q;
        end else begin
          run_d = run_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pll_tmr_store.sv
module pll_tmr_store #(
  parameter int            SW   = 17,
  parameter logic [SW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] next,
  input  logic [2:0]    upset_copy,
  input  logic [7:0]    upset_idx,
  output logic [SW-1:0] voted,
  output logic          err
);

  logic [SW-1:0] copy_q [3];
  logic [SW-1:0] flip;
  logic          disagree;

  assign flip = (upset_idx < 8'(SW)) ? ({{(SW-1){1'b0}}, 1'b1} << upset_idx) : '0;

  // every copy reloads from the voted next state, so one upset heals in a cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 3; k++) copy_q[k] <= INIT;
    end else begin
      for (int k = 0; k < 3; k++) copy_q[k] <= next ^ (upset_copy[k] ? flip : '0);
    end
  end

  assign voted    = (copy_q[0] & copy_q[1]) | (copy_q[0] & copy_q[2]) | (copy_q[1] & copy_q[2]);
  assign disagree = (copy_q[0] != copy_q[1]) || (copy_q[0] != copy_q[2]);

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= disagree;
  end

  // R11: a single-copy upset never reaches the voted state
  p_vote_masks_r11: assert property (@(posedge clk) disable iff (rst)
    ($countones(upset_copy) <= 1) |=> (voted == $past(next)))
    else $error("p_vote_masks_r11");

  // R11: without injection the copies agree again on the next edge
  p_heal_r11: assert property (@(posedge clk) disable iff (rst)
    (upset_copy == 3'b000) |=> !disagree)
    else $error("p_heal_r11");

  // R11: the flag is low whenever the copies agreed one cycle earlier
  p_err_follows_r11: assert property (@(posedge clk) disable iff (rst)
    !disagree |=> !err)
    else $error("p_err_follows_r11");

endmodule

// File: rtl/pll_cal_supervisor.sv
module pll_cal_supervisor
  import pll_sup_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int SETTLE_CYC = 4,
  parameter int CHECK_PER  = 4,
  parameter int LOCK_N     = 3,
  parameter int UNLOCK_M   = 2
) (
  input  logic              clk,
  input  logic              ext_ctrl,
  input  logic              auto_sel4,
  input  logic              restart_n_sel5,
  input  logic [CODE_W-3:0] range_lo,
  input  logic              too_fast,
  input  logic              raw_lock,
  input  logic [2:0]        upset_copy,
  input  logic [7:0]        upset_idx,
  output logic [CODE_W-1:0] range_code,
  output logic              locked,
  output logic              cal_busy,
  output logic              seu_err
);

  localparam int BIW     = $clog2(CODE_W);
  localparam int SCW     = $clog2(SETTLE_CYC);
  localparam int PCW     = $clog2(CHECK_PER);
  localparam int RUN_MAX = (LOCK_N > UNLOCK_M) ? LOCK_N : UNLOCK_M;
  localparam int RCW     = $clog2(RUN_MAX + 1);

  typedef struct packed {
    phase_e            ph;
    logic [BIW-1:0]    bidx;
    logic [CODE_W-1:0] code;
    logic [SCW-1:0]    settle;
    logic [PCW-1:0]    per;
    logic [RCW-1:0]    run;
    logic              filt;
  } ctl_t;

  localparam int SW = $bits(ctl_t);
  localparam ctl_t RST_ST = '{ph: PH_CAL, bidx: BIW'(CODE_W - 1),
                              code: {1'b1, {(CODE_W-1){1'b0}}},
                              settle: '0, per: '0, run: '0, filt: 1'b0};

  op_mode_e      mode;
  logic          rst;
  logic          manual;
  logic          lost;
  logic          relaunch;
  logic [SW-1:0] voted_vec;
  ctl_t          cur;
  ctl_t          nxt;

  // R2: the restart pin only resets outside manual mode
  assign rst      = !ext_ctrl && !restart_n_sel5;
  assign manual   = (mode == MODE_MANUAL);
  assign relaunch = lost && (mode == MODE_AUTO);
  assign cur      = ctl_t'(voted_vec);

  pll_mode_decode u_mode (
    .ext_ctrl  (ext_ctrl),
    .auto_sel4 (auto_sel4),
    .mode      (mode)
  );

  pll_cal_engine #(
    .CODE_W     (CODE_W),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_cal (
    .active   (!manual),
    .relaunch (relaunch),
    .too_fast (too_fast),
    .ph_q     (cur.ph),
    .bit_q    (cur.bidx),
    .code_q   (cur.code),
    .settle_q (cur.settle),
    .ph_d     (nxt.ph),
    .bit_d    (nxt.bidx),
    .code_d   (nxt.code),
    .settle_d (nxt.settle)
  );

  pll_lock_filter #(
    .CHECK_PER (CHECK_PER),
    .LOCK_N    (LOCK_N),
    .UNLOCK_M  (UNLOCK_M)
  ) u_filt (
    .active   (!manual),
    .tracking (cur.ph == PH_TRACK),
    .raw_lock (raw_lock),
    .per_q    (cur.per),
    .run_q    (cur.run),
    .filt_q   (cur.filt),
    .per_d    (nxt.per),
    .run_d    (nxt.run),
    .filt_d   (nxt.filt),
    .lost     (lost)
  );

  pll_tmr_store #(
    .SW   (SW),
    .INIT (RST_ST)
  ) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .next       (nxt),
    .upset_copy (upset_copy),
    .upset_idx  (upset_idx),
    .voted      (voted_vec),
    .err        (seu_err)
  );

  // registered outputs; manual mode bypasses the calibrated state
  always_ff @(posedge clk) begin
    if (rst) begin
      range_code <= RST_ST.code;
      locked     <= 1'b0;
      cal_busy   <= 1'b1;
    end else if (manual) begin
      range_code <= {restart_n_sel5, auto_sel4, range_lo};
      locked     <= raw_lock;
      cal_busy   <= 1'b0;
    end else begin
      range_code <= cur.code;
      locked     <= (cur.ph == PH_TRACK) && cur.filt;
      cal_busy   <= (cur.ph == PH_CAL);
    end
  end

  logic [CODE_W-1:0] below_mask;
  assign below_mask = ({{(CODE_W-1){1'b0}}, 1'b1} << cur.bidx) - 1'b1;

  // R3: bits below the trial position stay clear during the search
  p_sar_low_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (cur.ph == PH_CAL) |-> ((cur.code & below_mask) == '0))
    else $error("p_sar_low_clear_r3");

  // R6: busy and locked are never high together
  p_busy_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
    cal_busy |-> !locked)
    else $error("p_busy_unlocked_r6");

  // R7: hold mode never leaves tracking by itself
  p_hold_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD && cur.ph == PH_TRACK) |=> (cur.ph == PH_TRACK))
    else $error("p_hold_keeps_r7");

  // R8: a filtered lock drop in auto mode starts a new search
  p_auto_relaunch_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_AUTO && cur.ph == PH_TRACK && cur.filt && !nxt.filt) |=> (cur.ph == PH_CAL))
    else $error("p_auto_relaunch_r8");

  // R9: manual code comes from the pins one edge later
  p_manual_code_r9: assert property (@(posedge clk) disable iff (rst)
    $past(ext_ctrl) |-> (range_code == $past({restart_n_sel5, auto_sel4, range_lo})))
    else $error("p_manual_code_r9");

  // R10: manual lock output is the raw bit one edge later
  p_manual_lock_r10: assert property (@(posedge clk) disable iff (rst)
    $past(ext_ctrl) |-> (locked == $past(raw_lock) && !cal_busy))
    else $error("p_manual_lock_r10");

endmodule

// File: tb/tb_pll_cal_supervisor.sv
module tb_pll_cal_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 6;
  localparam int ST   = 4;
  localparam int PER  = 4;
  localparam int NL   = 3;
  localparam int MU   = 2;
  localparam int CAL_EDGES = CW * ST;

  logic          clk = 1'b0;
  logic          ext_ctrl, auto_sel4, restart_n_sel5, too_fast, raw_lock;
  logic [CW-3:0] range_lo;
  logic [2:0]    upset_copy;
  logic [7:0]    upset_idx;
  logic [CW-1:0] range_code;
  logic          locked, cal_busy, seu_err;
  logic [CW-1:0] thr;
  int            checks = 0;
  int            errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // plant model: oscillator too fast when the code exceeds the threshold
  assign too_fast = (range_code > thr);

  pll_cal_supervisor #(
    .CODE_W (CW), .SETTLE_CYC (ST), .CHECK_PER (PER), .LOCK_N (NL), .UNLOCK_M (MU)
  ) dut (
    .clk (clk), .ext_ctrl (ext_ctrl), .auto_sel4 (auto_sel4),
    .restart_n_sel5 (restart_n_sel5), .range_lo (range_lo), .too_fast (too_fast),
    .raw_lock (raw_lock), .upset_copy (upset_copy), .upset_idx (upset_idx),
    .range_code (range_code), .locked (locked), .cal_busy (cal_busy), .seu_err (seu_err)
  );

  function automatic logic [CW-1:0] sar_expect(input logic [CW-1:0] th);
    logic [CW-1:0] c;
    c = '0;
    for (int b = CW - 1; b >= 0; b--) begin
      logic [CW-1:0] t;
      t = c | (CW'(1) << b);
      if (t <= th) c = t;
    end
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cal(input logic [CW-1:0] th, input logic autob);
    int bad;
    bad = 0;
    thr = th; auto_sel4 = autob; raw_lock = 1'b0; restart_n_sel5 = 1'b0;
    step(2);
    restart_n_sel5 = 1'b1;
    for (int k = 1; k <= CAL_EDGES; k++) begin
      step(1);
      if (locked !== 1'b0 || cal_busy !== 1'b1) bad++;
    end
    chk("R6 busy high and locked low during search", bad, 0);
    step(1);
    chk("R3 busy falls at edge 6*SETTLE+1", int'(cal_busy), 0);
    chk("R3 search result", int'(range_code), int'(sar_expect(th)));
  endtask

  task automatic acquire();
    int bad;
    bad = 0;
    raw_lock = 1'b1;
    for (int k = 0; k < (NL - 1) * PER; k++) begin step(1); if (locked !== 1'b0) bad++; end
    raw_lock = 1'b0;
    for (int k = 0; k < PER; k++) begin step(1); if (locked !== 1'b0) bad++; end
    raw_lock = 1'b1;
    for (int k = 0; k < (NL - 1) * PER + 1; k++) begin step(1); if (locked !== 1'b0) bad++; end
    chk("R4 no lock before LOCK_N high samples", bad, 0);
    step(PER);
    chk("R4 lock after LOCK_N high samples", int'(locked), 1);
  endtask

  task automatic lose(input logic expect_recal, input logic [CW-1:0] new_th);
    int bad;
    logic [CW-1:0] held;
    bad = 0;
    held = range_code;
    thr = new_th;
    raw_lock = 1'b0;
    for (int k = 0; k < (MU - 1) * PER; k++) begin step(1); if (locked !== 1'b1) bad++; end
    raw_lock = 1'b1;
    for (int k = 0; k < PER; k++) begin step(1); if (locked !== 1'b1) bad++; end
    raw_lock = 1'b0;
    for (int k = 0; k < (MU - 1) * PER + 1; k++) begin step(1); if (locked !== 1'b1) bad++; end
    chk("R5 lock kept before UNLOCK_M low samples", bad, 0);
    step(PER);
    chk("R5 lock dropped after UNLOCK_M low samples", int'(locked), 0);
    if (expect_recal) begin
      chk("R8 busy rises with the lock drop", int'(cal_busy), 1);
      step(CAL_EDGES + 2);
      chk("R8 recalibrated busy", int'(cal_busy), 0);
      chk("R8 recalibrated code", int'(range_code), int'(sar_expect(new_th)));
    end else begin
      chk("R7 no busy on lock drop", int'(cal_busy), 0);
      bad = 0;
      for (int k = 0; k < CAL_EDGES + 2; k++) begin
        step(1);
        if (cal_busy !== 1'b0 || range_code !== held) bad++;
      end
      chk("R7 code held after lock loss", bad, 0);
    end
  endtask

  task automatic inject(input int copy, input logic [7:0] idx);
    logic [CW-1:0] c0;
    logic          l0;
    c0 = range_code; l0 = locked;
    chk("R11 flag idle before upset", int'(seu_err), 0);
    upset_copy = 3'b001 << copy; upset_idx = idx;
    step(1);
    upset_copy = 3'b000;
    chk("R11 flag low on injecting edge", int'(seu_err), 0);
    step(1);
    chk("R11 flag pulse", int'(seu_err), 1);
    chk("R11 code unaffected", int'(range_code), int'(c0));
    chk("R11 lock unaffected", int'(locked), int'(l0));
    step(1);
    chk("R11 flag cleared", int'(seu_err), 0);
    chk("R11 code still unaffected", int'(range_code), int'(c0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] last_exp;
    void'($urandom(32'd4321));
    ext_ctrl = 1'b0; auto_sel4 = 1'b0; restart_n_sel5 = 1'b0; range_lo = '0;
    raw_lock = 1'b0; upset_copy = 3'b000; upset_idx = 8'd0; thr = '0;
    step(3);
    chk("R2 reset code", int'(range_code), 32);
    chk("R2 reset locked", int'(locked), 0);
    chk("R2 reset busy", int'(cal_busy), 1);
    chk("R2 reset error flag", int'(seu_err), 0);

    // auto mode: search, lock, drop and relaunch
    do_cal(6'd37, 1'b1);
    acquire();
    lose(1'b1, 6'd12);

    // hold mode: boundary code 0, loss keeps the code
    do_cal(6'd0, 1'b0);
    acquire();
    lose(1'b0, 6'd50);

    // boundary top code and random thresholds
    do_cal(6'd63, 1'b0);
    last_exp = 6'd63;
    for (int i = 0; i < 4; i++) begin
      logic [CW-1:0] th;
      th = CW'($urandom % 64);
      do_cal(th, i[0]);
      last_exp = sar_expect(th);
    end

    // voting under single-copy upsets while locked in hold mode
    auto_sel4 = 1'b0;
    acquire();
    for (int i = 0; i < 10; i++) inject(int'($urandom % 3), 8'($urandom % 8));

    // manual mode: R1 directed case then random pins
    ext_ctrl = 1'b1; auto_sel4 = 1'b1; restart_n_sel5 = 1'b0; range_lo = 4'h5; raw_lock = 1'b0;
    step(1);
    chk("R1 manual wins over auto-restart pin", int'(range_code), 6'h15);
    chk("R1 manual mode not busy", int'(cal_busy), 0);
    for (int i = 0; i < 30; i++) begin
      logic [6:0] r;
      r = 7'($urandom);
      restart_n_sel5 = r[6]; auto_sel4 = r[5]; range_lo = r[4:1]; raw_lock = r[0];
      thr = CW'($urandom);
      step(1);
      chk("R9 manual code from pins", int'(range_code), int'(r[6:1]));
      chk("R10 manual raw lock", int'(locked), int'(r[0]));
      chk("R10 manual busy low", int'(cal_busy), 0);
    end
    ext_ctrl = 1'b0; restart_n_sel5 = 1'b1; auto_sel4 = 1'b0; raw_lock = 1'b1;
    step(1);
    chk("R9 calibrated code frozen through manual mode", int'(range_code), int'(last_exp));
    chk("R1 hold mode after manual exit", int'(cal_busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule